// File: doc/BRIEF.md
# Source Power Request Policy Checker

This block sits on the source side of a USB Power Delivery port, between a protocol engine that has already decoded the sink's request and the regulator that produces the bus voltage. A request arrives as three fields: a one-based object position, a voltage and a current. The block looks up the selected entry in a small table of offers that software loads. It then tests the request against the port's power budget and against what the attached cable can carry. The result is a one-cycle accept or reject response. On accept, it also produces a new voltage and current command for the regulator.

Offers are either fixed-voltage or programmable (PPS). A programmable offer covers a voltage window, and the sink chooses a point inside it. The block will not drive the regulator past the cable's limits. Without a high-current cable, no request above 3 A is accepted. Without an extended-voltage cable, any offer above 20 V is treated as absent. While a programmable contract is active, each new programmable point must stay within a configured voltage step of the current command, and must wait a configured minimum interval since the last accepted change.

After an accept the block waits for the regulator to report that the new point has been reached, then pulses its ready output. If the regulator stays silent past a configured number of cycles, the transition is aborted, a fault pulse is raised and the previous command is restored.

Top module: `src_req_policy`

## Requirements
- R1: A request is rejected until a capabilities-advertised pulse (`cap_adv`) has been seen. Any write to the offer table withdraws that advertisement until the next pulse.
- R2: Object position 0, or a position greater than `cfg_len`, is rejected. Position p selects table entry p-1.
- R3: For a fixed entry (kind 0), the command voltage is the entry's upper voltage and `req_v` is ignored. The request is rejected if `req_i` exceeds the entry's current limit.
- R4: For a programmable entry (kind 1), `req_v` must lie within the entry's lower and upper voltages inclusive, and must be even in 10 mV units (a 20 mV grid). The command voltage is then `req_v`.
- R5: With `cable_hi_cur` low, any request above 300 (3 A in 10 mA units) is rejected, whatever the entry allows.
- R6: With `cable_ext_v` low, every entry whose upper voltage exceeds 2000 (20 V) is rejected as if absent.
- R7: A request is rejected when command voltage times `req_i` exceeds `cfg_budget`, in units of 0.1 mW.
- R8: When the active contract is programmable, a programmable request is rejected in two cases. The first is when its distance from the present command voltage exceeds `cfg_pps_step`. The second is when fewer than `cfg_pps_gap` clock cycles have passed between the last accepting edge and the sampling edge, not counting either edge.
- R9: Each sampled `req_valid` produces a one-cycle `resp_valid` in the next cycle. On reject, `cmd_v` and `cmd_i` stay unchanged.
- R10: On accept, `cmd_v`/`cmd_i` take the new values in the same cycle as the response and `busy` goes high. Requests that arrive while busy are rejected.
- R11: `ps_ready` pulses for one cycle after `stage_ready` is sampled while busy, and `busy` then falls. While idle, `stage_ready` has no effect.
- R12: If `stage_ready` is not seen, `fault` pulses `cfg_timeout`+1 cycles after the accept response. At the same time the previous command and contract kind are restored.
- R13: After reset the command is 5 V / 3 A (500 / 300), and `resp_valid`, `busy`, `ps_ready` and `fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the offer table |
| cfg_idx | input | 3 | Table entry written (0..6) |
| cfg_kind | input | 1 | Entry kind: 0 fixed, 1 programmable |
| cfg_v_lo | input | 12 | Lower voltage of a programmable entry, 10 mV units |
| cfg_v_hi | input | 12 | Entry voltage (fixed) or upper voltage, 10 mV units |
| cfg_imax | input | 10 | Entry current limit, 10 mA units |
| cfg_len | input | 3 | Number of valid entries |
| cfg_budget | input | 24 | Port power budget, 0.1 mW units |
| cfg_pps_step | input | 12 | Largest programmable voltage step, 10 mV units |
| cfg_pps_gap | input | 16 | Minimum cycles between programmable updates |
| cfg_timeout | input | 16 | Cycles allowed for the regulator to report ready |
| cable_hi_cur | input | 1 | Cable is rated for 5 A |
| cable_ext_v | input | 1 | Cable supports the extended voltage range |
| cap_adv | input | 1 | Pulse: capabilities have been advertised |
| req_valid | input | 1 | Decoded request present |
| req_pos | input | 3 | Requested object position (one-based) |
| req_v | input | 12 | Requested voltage, 10 mV units |
| req_i | input | 10 | Requested current, 10 mA units |
| stage_ready | input | 1 | Regulator has reached the commanded point |
| resp_valid | output | 1 | Response pulse |
| resp_accept | output | 1 | Response is an accept |
| cmd_v | output | 12 | Voltage command to the regulator |
| cmd_i | output | 10 | Current command to the regulator |
| busy | output | 1 | Transition in progress |
| ps_ready | output | 1 | Pulse: new operating point confirmed |
| fault | output | 1 | Pulse: transition aborted on timeout |

## Verification
The hardest state to reach is a programmable-to-programmable update that lands right at the edge of the minimum update interval, since it needs an accepted programmable contract and then an exact count of idle cycles. The stimulus gets there by drawing random idle gaps that straddle the configured interval after each completed transition. A directed sequence then requests again in the cycle just after ready, which is too early. A timeout abort out of a busy transition is set up directly by withholding `stage_ready`, and the bench counts cycles to the fault pulse and checks that the prior command is restored.

// File: rtl/src_req_pkg.sv
package src_req_pkg;

    parameter int V_W = 12;   // voltage in 10 mV units
    parameter int I_W = 10;   // current in 10 mA units
    parameter int P_W = 24;   // power in 0.1 mW units

    typedef enum logic {
        ENT_FIXED = 1'b0,
        ENT_PPS   = 1'b1
    } ent_kind_e;

    typedef struct packed {
        ent_kind_e       kind;
        logic [V_W-1:0]  v_lo;
        logic [V_W-1:0]  v_hi;
        logic [I_W-1:0]  imax;
    } ent_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } seq_st_e;

endpackage

// File: rtl/src_req_table.sv
module src_req_table
    import src_req_pkg::*;
#(
    parameter int N_ENT = 7,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  ent_t             wdata,
    input  logic [IDX_W-1:0] ridx,
    output ent_t             rdata
);

    ent_t ent_d [N_ENT];
    ent_t ent_q [N_ENT];

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        always_comb begin
            ent_d[g] = ent_q[g];
            if (we && (widx == IDX_W'(g))) begin
                ent_d[g] = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q[g] <= '0;
            end else begin
                ent_q[g] <= ent_d[g];
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < N_ENT; k++) begin
            if (ridx == IDX_W'(k)) begin
                rdata = ent_q[k];
            end
        end
    end

endmodule

// File: rtl/src_req_eval.sv
module src_req_eval
    import src_req_pkg::*;
#(
    parameter int             POS_W     = 3,
    parameter logic [V_W-1:0] EPR_V_LIM = 12'd2000,
    parameter logic [I_W-1:0] CBL_I_LIM = 10'd300
) (
    input  ent_t             ent,
    input  logic [POS_W-1:0] pos,
    input  logic [POS_W-1:0] len,
    input  logic [V_W-1:0]   req_v,
    input  logic [I_W-1:0]   req_i,
    input  logic             cable_hi_cur,
    input  logic             cable_ext_v,
    input  logic [P_W-1:0]   budget,
    input  logic [V_W-1:0]   max_step,
    input  logic [V_W-1:0]   cur_v,
    input  logic             cur_pps,
    input  logic             gap_ok,
    input  logic             adv,
    input  logic             busy,
    output logic             ok,
    output logic [V_W-1:0]   tgt_v,
    output logic [I_W-1:0]   tgt_i,
    output logic             tgt_pps
);

    localparam int PR_W  = V_W + I_W;
    localparam int CMP_W = (PR_W > P_W) ? PR_W : P_W;

    logic           pos_ok;
    logic           hidden;
    logic           is_pps;
    logic [I_W-1:0] i_lim;
    logic           i_ok;
    logic           v_ok;
    logic [PR_W-1:0] pwr;
    logic           pwr_ok;
    logic [V_W-1:0] step;
    logic           slew_ok;

    always_comb begin
        pos_ok  = (pos != '0) && (pos <= len);
        // offers above the standard range vanish without a capable cable
        hidden  = (ent.v_hi > EPR_V_LIM) && !cable_ext_v;
        is_pps  = (ent.kind == ENT_PPS);
        // current ceiling narrows to the plain-cable rating
        i_lim   = (!cable_hi_cur && (ent.imax > CBL_I_LIM)) ? CBL_I_LIM : ent.imax;

        tgt_v   = is_pps ? req_v : ent.v_hi;
        tgt_i   = req_i;
        tgt_pps = is_pps;

        i_ok    = (req_i <= i_lim);
        v_ok    = !is_pps || ((req_v >= ent.v_lo) && (req_v <= ent.v_hi) && !req_v[0]);

        pwr     = PR_W'(tgt_v) * PR_W'(req_i);
        pwr_ok  = CMP_W'(pwr) <= CMP_W'(budget);

        step    = (req_v >= cur_v) ? (req_v - cur_v) : (cur_v - req_v);
        slew_ok = !(is_pps && cur_pps) || ((step <= max_step) && gap_ok);

        ok = adv && !busy && pos_ok && !hidden && i_ok && v_ok && pwr_ok && slew_ok;
    end

endmodule

// File: rtl/src_req_seq.sv
module src_req_seq
    import src_req_pkg::*;
#(
    parameter int             TMR_W = 16,
    parameter int             GAP_W = 16,
    parameter logic [V_W-1:0] DEF_V = 12'd500,
    parameter logic [I_W-1:0] DEF_I = 10'd300
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tbl_we,
    input  logic             cap_adv,
    input  logic             req_valid,
    input  logic             req_ok,
    input  logic [V_W-1:0]   tgt_v,
    input  logic [I_W-1:0]   tgt_i,
    input  logic             tgt_pps,
    input  logic             stage_ready,
    input  logic [TMR_W-1:0] timeout,
    input  logic [GAP_W-1:0] min_gap,
    output logic             adv,
    output logic             busy,
    output logic             gap_ok,
    output logic [V_W-1:0]   cur_v,
    output logic [I_W-1:0]   cur_i,
    output logic             cur_pps,
    output logic             resp_valid,
    output logic             resp_ok,
    output logic             rdy,
    output logic             flt
);

    typedef struct packed {
        seq_st_e         st;
        logic [TMR_W-1:0] tmr;
        logic [GAP_W-1:0] gap;
        logic            adv;
        logic [V_W-1:0]  cv;
        logic [I_W-1:0]  ci;
        logic            cpps;
        logic [V_W-1:0]  pv;
        logic [I_W-1:0]  pi;
        logic            ppps;
        logic            resp_v;
        logic            resp_ok;
        logic            rdy;
        logic            flt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.resp_v  = 1'b0;
        s_d.resp_ok = 1'b0;
        s_d.rdy     = 1'b0;
        s_d.flt     = 1'b0;

        if (s_q.gap != '1) begin
            s_d.gap = s_q.gap + 1'b1;
        end

        if (tbl_we) begin
            s_d.adv = 1'b0;
        end else if (cap_adv) begin
            s_d.adv = 1'b1;
        end

        if (req_valid) begin
            s_d.resp_v  = 1'b1;
            s_d.resp_ok = req_ok;
            if (req_ok) begin
                s_d.pv   = s_q.cv;
                s_d.pi   = s_q.ci;
                s_d.ppps = s_q.cpps;
                s_d.cv   = tgt_v;
                s_d.ci   = tgt_i;
                s_d.cpps = tgt_pps;
                s_d.st   = ST_WAIT;
                s_d.tmr  = '0;
                s_d.gap  = '0;
            end
        end

        if (s_q.st == ST_WAIT) begin
            if (stage_ready) begin
                s_d.rdy = 1'b1;
                s_d.st  = ST_IDLE;
            end else if (s_q.tmr == timeout) begin
                s_d.flt  = 1'b1;
                s_d.st   = ST_IDLE;
                s_d.cv   = s_q.pv;
                s_d.ci   = s_q.pi;
                s_d.cpps = s_q.ppps;
            end else begin
                s_d.tmr = s_q.tmr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= ST_IDLE;
            s_q.gap  <= '1;
            s_q.cv   <= DEF_V;
            s_q.ci   <= DEF_I;
            s_q.pv   <= DEF_V;
            s_q.pi   <= DEF_I;
        end else begin
            s_q <= s_d;
        end
    end

    assign adv        = s_q.adv;
    assign busy       = (s_q.st == ST_WAIT);
    assign gap_ok     = (s_q.gap >= min_gap);
    assign cur_v      = s_q.cv;
    assign cur_i      = s_q.ci;
    assign cur_pps    = s_q.cpps;
    assign resp_valid = s_q.resp_v;
    assign resp_ok    = s_q.resp_ok;
    assign rdy        = s_q.rdy;
    assign flt        = s_q.flt;

endmodule

// File: rtl/src_req_policy.sv
module src_req_policy
    import src_req_pkg::*;
#(
    parameter int             N_ENT     = 7,
    parameter int             TMR_W     = 16,
    parameter int             GAP_W     = 16,
    parameter logic [V_W-1:0] EPR_V_LIM = 12'd2000,
    parameter logic [I_W-1:0] CBL_I_LIM = 10'd300,
    parameter logic [V_W-1:0] DEF_V     = 12'd500,
    parameter logic [I_W-1:0] DEF_I     = 10'd300,
    localparam int            IDX_W     = $clog2(N_ENT),
    localparam int            POS_W     = $clog2(N_ENT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic             cfg_kind,
    input  logic [V_W-1:0]   cfg_v_lo,
    input  logic [V_W-1:0]   cfg_v_hi,
    input  logic [I_W-1:0]   cfg_imax,
    input  logic [POS_W-1:0] cfg_len,
    input  logic [P_W-1:0]   cfg_budget,
    input  logic [V_W-1:0]   cfg_pps_step,
    input  logic [GAP_W-1:0] cfg_pps_gap,
    input  logic [TMR_W-1:0] cfg_timeout,
    input  logic             cable_hi_cur,
    input  logic             cable_ext_v,
    input  logic             cap_adv,
    input  logic             req_valid,
    input  logic [POS_W-1:0] req_pos,
    input  logic [V_W-1:0]   req_v,
    input  logic [I_W-1:0]   req_i,
    input  logic             stage_ready,
    output logic             resp_valid,
    output logic             resp_accept,
    output logic [V_W-1:0]   cmd_v,
    output logic [I_W-1:0]   cmd_i,
    output logic             busy,
    output logic             ps_ready,
    output logic             fault
);

    ent_t           wr_ent;
    ent_t           sel_ent;
    logic [IDX_W-1:0] sel_idx;
    logic           ev_ok;
    logic [V_W-1:0] ev_v;
    logic [I_W-1:0] ev_i;
    logic           ev_pps;
    logic           adv;
    logic           gap_ok;
    logic           cur_pps;

    always_comb begin
        wr_ent.kind = ent_kind_e'(cfg_kind);
        wr_ent.v_lo = cfg_v_lo;
        wr_ent.v_hi = cfg_v_hi;
        wr_ent.imax = cfg_imax;
        sel_idx     = IDX_W'(req_pos - 1'b1);
    end

    src_req_table #(
        .N_ENT (N_ENT),
        .IDX_W (IDX_W)
    ) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .widx  (cfg_idx),
        .wdata (wr_ent),
        .ridx  (sel_idx),
        .rdata (sel_ent)
    );

    src_req_eval #(
        .POS_W     (POS_W),
        .EPR_V_LIM (EPR_V_LIM),
        .CBL_I_LIM (CBL_I_LIM)
    ) u_eval (
        .ent          (sel_ent),
        .pos          (req_pos),
        .len          (cfg_len),
        .req_v        (req_v),
        .req_i        (req_i),
        .cable_hi_cur (cable_hi_cur),
        .cable_ext_v  (cable_ext_v),
        .budget       (cfg_budget),
        .max_step     (cfg_pps_step),
        .cur_v        (cmd_v),
        .cur_pps      (cur_pps),
        .gap_ok       (gap_ok),
        .adv          (adv),
        .busy         (busy),
        .ok           (ev_ok),
        .tgt_v        (ev_v),
        .tgt_i        (ev_i),
        .tgt_pps      (ev_pps)
    );

    src_req_seq #(
        .TMR_W (TMR_W),
        .GAP_W (GAP_W),
        .DEF_V (DEF_V),
        .DEF_I (DEF_I)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tbl_we      (cfg_we),
        .cap_adv     (cap_adv),
        .req_valid   (req_valid),
        .req_ok      (ev_ok),
        .tgt_v       (ev_v),
        .tgt_i       (ev_i),
        .tgt_pps     (ev_pps),
        .stage_ready (stage_ready),
        .timeout     (cfg_timeout),
        .min_gap     (cfg_pps_gap),
        .adv         (adv),
        .busy        (busy),
        .gap_ok      (gap_ok),
        .cur_v       (cmd_v),
        .cur_i       (cmd_i),
        .cur_pps     (cur_pps),
        .resp_valid  (resp_valid),
        .resp_ok     (resp_accept),
        .rdy         (ps_ready),
        .flt         (fault)
    );

endmodule

// File: rtl/src_req_policy_chk.sv
module src_req_policy_chk
    import src_req_pkg::*;
#(
    parameter logic [V_W-1:0] EPR_V_LIM = 12'd2000,
    parameter logic [I_W-1:0] CBL_I_LIM = 10'd300
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cable_hi_cur,
    input logic           cable_ext_v,
    input logic [P_W-1:0] cfg_budget,
    input logic           stage_ready,
    input logic           resp_valid,
    input logic           resp_accept,
    input logic [V_W-1:0] cmd_v,
    input logic [I_W-1:0] cmd_i,
    input logic           busy,
    input logic           ps_ready,
    input logic           fault
);

    // R9: a rejection leaves the regulator command untouched
    p_reject_keeps_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_accept) |-> ($stable(cmd_v) && $stable(cmd_i)));

    // R10: an accept always opens a transition
    p_accept_opens_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_accept) |-> busy);

    // R10: a transition only starts with an accept response
    p_busy_from_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (resp_valid && resp_accept));

    // R11: ready only follows a regulator confirmation during a transition
    p_ready_after_stage_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ps_ready |-> ($past(stage_ready) && $past(busy)));

    // R12: a fault only ends an unconfirmed transition
    p_fault_unconfirmed_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> ($past(busy) && !$past(stage_ready) && !ps_ready));

    // R5: plain cable never receives a high-current command
    p_cable_current_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_accept && !$past(cable_hi_cur)) |-> (cmd_i <= CBL_I_LIM));

    // R6: no extended-range voltage without a capable cable
    p_ext_voltage_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_accept && !$past(cable_ext_v)) |-> (cmd_v <= EPR_V_LIM));

    // R7: accepted command stays inside the budget
    p_budget_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_accept) |-> ((int'(cmd_v) * int'(cmd_i)) <= int'($past(cfg_budget))));

endmodule

bind src_req_policy src_req_policy_chk #(
    .EPR_V_LIM (EPR_V_LIM),
    .CBL_I_LIM (CBL_I_LIM)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cable_hi_cur (cable_hi_cur),
    .cable_ext_v  (cable_ext_v),
    .cfg_budget   (cfg_budget),
    .stage_ready  (stage_ready),
    .resp_valid   (resp_valid),
    .resp_accept  (resp_accept),
    .cmd_v        (cmd_v),
    .cmd_i        (cmd_i),
    .busy         (busy),
    .ps_ready     (ps_ready),
    .fault        (fault)
);

// File: tb/src_req_policy_tb.sv
`timescale 1ns/1ps
module src_req_policy_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic        cfg_kind = 1'b0;
    logic [11:0] cfg_v_lo = '0;
    logic [11:0] cfg_v_hi = '0;
    logic [9:0]  cfg_imax = '0;
    logic [2:0]  cfg_len = 3'd7;
    logic [23:0] cfg_budget = 24'd1000000;
    logic [11:0] cfg_pps_step = 12'd150;
    logic [15:0] cfg_pps_gap = 16'd8;
    logic [15:0] cfg_timeout = 16'd40;
    logic        cable_hi_cur = 1'b1;
    logic        cable_ext_v = 1'b1;
    logic        cap_adv = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_pos = '0;
    logic [11:0] req_v = '0;
    logic [9:0]  req_i = '0;
    logic        stage_ready = 1'b0;
    logic        resp_valid, resp_accept, busy, ps_ready, fault;
    logic [11:0] cmd_v;
    logic [9:0]  cmd_i;

    src_req_policy u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_kind(cfg_kind),
        .cfg_v_lo(cfg_v_lo), .cfg_v_hi(cfg_v_hi), .cfg_imax(cfg_imax), .cfg_len(cfg_len),
        .cfg_budget(cfg_budget), .cfg_pps_step(cfg_pps_step), .cfg_pps_gap(cfg_pps_gap),
        .cfg_timeout(cfg_timeout), .cable_hi_cur(cable_hi_cur), .cable_ext_v(cable_ext_v),
        .cap_adv(cap_adv), .req_valid(req_valid), .req_pos(req_pos), .req_v(req_v),
        .req_i(req_i), .stage_ready(stage_ready), .resp_valid(resp_valid),
        .resp_accept(resp_accept), .cmd_v(cmd_v), .cmd_i(cmd_i), .busy(busy),
        .ps_ready(ps_ready), .fault(fault)
    );

    always #2 clk = ~clk;

    int ecnt = 0;
    always @(posedge clk) ecnt <= ecnt + 1;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    // bench model
    int m_kind [7];
    int m_lo [7];
    int m_hi [7];
    int m_im [7];
    int m_len = 7;
    bit m_adv = 1'b0;
    bit m_busy = 1'b0;
    int m_cv = 500, m_ci = 300, m_pps = 0;
    int m_pv = 500, m_pi = 300, m_ppps = 0;
    int last_acc = -1;

    task automatic check(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_ok(int pos, int v, int i, int eidx);
        int e, lim, tv, d, g;
        if (!m_adv || m_busy) return 1'b0;
        if (pos < 1 || pos > m_len) return 1'b0;
        e = pos - 1;
        if (m_hi[e] > 2000 && !cable_ext_v) return 1'b0;
        lim = m_im[e];
        if (!cable_hi_cur && lim > 300) lim = 300;
        if (i > lim) return 1'b0;
        tv = (m_kind[e] == 1) ? v : m_hi[e];
        if (m_kind[e] == 1 && (v < m_lo[e] || v > m_hi[e] || (v % 2) != 0)) return 1'b0;
        if (tv * i > int'(cfg_budget)) return 1'b0;
        if (m_kind[e] == 1 && m_pps == 1) begin
            d = (v > m_cv) ? v - m_cv : m_cv - v;
            if (d > int'(cfg_pps_step)) return 1'b0;
            if (last_acc >= 0) begin
                g = eidx - last_acc - 1;
                if (g > 65535) g = 65535;
                if (g < int'(cfg_pps_gap)) return 1'b0;
            end
        end
        return 1'b1;
    endfunction

    task automatic wr_ent(int idx, int kind, int lo, int hi, int im);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_kind = kind[0];
        cfg_v_lo = 12'(lo); cfg_v_hi = 12'(hi); cfg_imax = 10'(im);
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
        m_kind[idx] = kind; m_lo[idx] = lo; m_hi[idx] = hi; m_im[idx] = im;
        m_adv = 1'b0;
    endtask

    task automatic advertise();
        cap_adv = 1'b1;
        @(posedge clk); @(negedge clk);
        cap_adv = 1'b0;
        m_adv = 1'b1;
    endtask

    task automatic finish_ok(string tag, int k);
        repeat (k) begin
            @(posedge clk); @(negedge clk);
            check({tag, " R11 no ready before stage"}, int'(ps_ready), 0);
        end
        stage_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        stage_ready = 1'b0;
        check({tag, " R11 ready pulse"}, int'(ps_ready), 1);
        check({tag, " R11 busy cleared"}, int'(busy), 0);
        m_busy = 1'b0;
    endtask

    task automatic request(string tag, int pos, int v, int i, int k, bit fin, output bit acc);
        int eidx;
        bit e;
        eidx = ecnt + 1;
        e = exp_ok(pos, v, i, eidx);
        req_valid = 1'b1; req_pos = 3'(pos); req_v = 12'(v); req_i = 10'(i);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R9 resp_valid"}, int'(resp_valid), 1);
        check({tag, " accept"}, int'(resp_accept), int'(e));
        if (e) begin
            m_pv = m_cv; m_pi = m_ci; m_ppps = m_pps;
            m_cv = (m_kind[pos-1] == 1) ? v : m_hi[pos-1];
            m_ci = i; m_pps = m_kind[pos-1];
            last_acc = eidx;
            m_busy = 1'b1;
            check({tag, " R10 busy"}, int'(busy), 1);
        end
        check({tag, " R10 cmd_v"}, int'(cmd_v), m_cv);
        check({tag, " R10 cmd_i"}, int'(cmd_i), m_ci);
        acc = e;
        if (e && fin) finish_ok(tag, k);
    endtask

    initial begin : main
        bit a;
        int n;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R13: reset state
        check("R13 cmd_v", int'(cmd_v), 500);
        check("R13 cmd_i", int'(cmd_i), 300);
        check("R13 resp_valid", int'(resp_valid), 0);
        check("R13 busy", int'(busy), 0);
        check("R13 fault", int'(fault), 0);
        rst_n = 1'b1;
        @(negedge clk);

        wr_ent(0, 0, 0, 500, 300);
        wr_ent(1, 0, 0, 900, 300);
        wr_ent(2, 0, 0, 1500, 500);
        wr_ent(3, 0, 0, 2000, 500);
        wr_ent(4, 1, 330, 1100, 500);
        wr_ent(5, 0, 0, 2800, 500);
        wr_ent(6, 1, 1500, 2800, 500);

        // R1: nothing accepted before advertisement
        request("R1 before advertise", 1, 0, 100, 0, 1, a);
        check("R1 rejected", int'(a), 0);
        advertise();

        // R2: position bounds
        request("R2 position zero", 0, 0, 100, 0, 1, a);
        check("R2 pos0 rejected", int'(a), 0);
        cfg_len = 3'd5; m_len = 5;
        request("R2 beyond length", 6, 0, 100, 0, 1, a);
        check("R2 pos6 rejected", int'(a), 0);
        cfg_len = 3'd7; m_len = 7;

        // R3: fixed entry ignores req_v, checks current
        request("R3 fixed 9V", 2, 1234, 300, 2, 1, a);
        check("R3 fixed accepted", int'(a), 1);
        check("R3 fixed voltage from entry", int'(cmd_v), 900);
        request("R3 over current", 2, 900, 301, 0, 1, a);
        check("R3 overcurrent rejected", int'(a), 0);

        // R5: cable current clamp
        cable_hi_cur = 1'b0;
        request("R5 plain cable 4A", 3, 0, 400, 0, 1, a);
        check("R5 rejected", int'(a), 0);
        cable_hi_cur = 1'b1;
        request("R5 rated cable 4A", 3, 0, 400, 1, 1, a);
        check("R5 accepted", int'(a), 1);

        // R6: extended voltage hidden
        cable_ext_v = 1'b0;
        request("R6 28V hidden", 6, 0, 100, 0, 1, a);
        check("R6 rejected", int'(a), 0);
        cable_ext_v = 1'b1;
        request("R6 28V shown", 6, 0, 100, 1, 1, a);
        check("R6 accepted", int'(a), 1);
        check("R6 cmd 28V", int'(cmd_v), 2800);

        // R7: budget
        request("R7 over budget", 6, 0, 500, 0, 1, a);
        check("R7 rejected", int'(a), 0);
        request("R7 at budget", 4, 0, 500, 0, 1, a);
        check("R7 exactly 100W accepted", int'(a), 1);

        // R4: programmable window and grid
        request("R4 odd voltage", 5, 501, 200, 0, 1, a);
        check("R4 odd rejected", int'(a), 0);
        request("R4 below window", 5, 320, 200, 0, 1, a);
        check("R4 low rejected", int'(a), 0);
        request("R4 in window", 5, 600, 200, 1, 1, a);
        check("R4 accepted", int'(a), 1);
        check("R4 cmd follows request", int'(cmd_v), 600);

        // R8: step and interval limits
        request("R8 early update", 5, 640, 200, 0, 1, a);
        check("R8 early rejected", int'(a), 0);
        repeat (10) @(negedge clk);
        request("R8 big step", 5, 800, 200, 0, 1, a);
        check("R8 step rejected", int'(a), 0);
        request("R8 small step", 5, 700, 200, 0, 1, a);
        check("R8 step accepted", int'(a), 1);

        // R10: request while busy
        repeat (10) @(negedge clk);
        request("R10 open", 1, 0, 200, 0, 0, a);
        check("R10 opened", int'(a), 1);
        request("R10 during busy", 2, 0, 100, 0, 0, a);
        check("R10 busy rejected", int'(a), 0);
        finish_ok("R10 close", 1);

        // R11: stage_ready while idle
        stage_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        stage_ready = 1'b0;
        check("R11 idle stage ignored", int'(ps_ready), 0);

        // R12: timeout abort
        cfg_timeout = 16'd10;
        request("R12 open", 3, 0, 250, 0, 0, a);
        check("R12 opened", int'(a), 1);
        n = 0;
        while (!fault && n < 200) begin
            @(posedge clk); @(negedge clk);
            n++;
        end
        check("R12 cycles to fault", n, 11);
        m_cv = m_pv; m_ci = m_pi; m_pps = m_ppps; m_busy = 1'b0;
        check("R12 cmd_v restored", int'(cmd_v), m_cv);
        check("R12 cmd_i restored", int'(cmd_i), m_ci);
        check("R12 busy cleared", int'(busy), 0);
        cfg_timeout = 16'd40;

        // R1: table write withdraws advertisement
        wr_ent(0, 0, 0, 500, 300);
        request("R1 after table write", 1, 0, 100, 0, 1, a);
        check("R1 withdrawn", int'(a), 0);
        advertise();

        // random mix
        for (int it = 0; it < 250; it++) begin
            int pos, v, i, idle;
            if ($urandom_range(0, 7) == 0) begin
                cable_hi_cur = 1'($urandom_range(0, 1));
                cable_ext_v  = 1'($urandom_range(0, 1));
            end
            idle = $urandom_range(0, 12);
            repeat (idle) @(negedge clk);
            pos = $urandom_range(0, 7);
            if (pos >= 1 && m_kind[pos-1] == 1)
                v = $urandom_range(m_lo[pos-1] - 20, m_hi[pos-1] + 20);
            else if ($urandom_range(0, 1) == 1 && m_pps == 1)
                v = m_cv + $urandom_range(0, 300) - 150;
            else
                v = $urandom_range(0, 4095);
            if (v < 0) v = 0;
            if (v > 4095) v = 4095;
            i = $urandom_range(0, 550);
            if (pos < 1 || m_kind[pos-1] == 0) begin
                if ($urandom_range(0, 1) == 1) pos = 5;
                if (pos == 5) v = m_cv + $urandom_range(0, 300) - 150;
                if (v < 0) v = 0;
            end
            request("R4 random", pos, v, i, $urandom_range(0, 6), 1, a);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule